// File: doc/BRIEF.md
# Controller Configuration and Status Register Handler

This block holds the configuration register, the status register and the interrupt mask of a storage host interface. Software reaches it through 32-bit register writes on a simple memory-mapped bus. The block stores each configuration write and watches two fields for changes against the value held before the write: the enable bit and the shutdown-notification field. When a field changes, the block issues a one-cycle request to the rest of the controller and updates the status register.

The shutdown field is handled before the enable bit, so one write can issue a shutdown request and a start request together. Clearing the enable bit takes a reset path: configuration, status and mask return to zero, and any other status effect of that write is dropped. The start result comes back on `startOk` in the same cycle as the start request.

The block also has a virtual-function mode. In that mode an offline function discards configuration writes. A function reset reports controller-fatal status when the function is offline and clean status when it is online. Register offsets: interrupt mask set at 0x0C, interrupt mask clear at 0x10, configuration at 0x14.

Top module: `ctrl_cfg_regs`

## Requirements
- R1: An accepted write to configuration offset 0x14 that does not clear the enable bit stores the full 32-bit written value into `ccQ` one cycle later.
- R2: When the shutdown field (bits 15:14) changes from zero to nonzero, `shutdownReq` pulses in the write cycle. In the next cycle the shutdown-status field of `cstsQ` (bits 3:2) reads 2'b10.
- R3: When the shutdown field changes from nonzero to zero, status bits 3:2 are cleared and `shutdownReq` stays low.
- R4: When the enable bit (bit 0) rises, `startReq` pulses in the write cycle. If `startOk` is 1 in that cycle, ready (`cstsQ` bit 0) is set and all other status bits keep the values the shutdown handling gave them.
- R5: When the enable bit rises and `startOk` is 0, `cstsQ` becomes exactly 32'h2, which is the controller-fatal bit alone.
- R6: When the enable bit falls, `ccQ`, `intMaskQ` and `cstsQ` all become zero. A shutdown request caused by the same write still pulses.
- R7: A single write that raises both the enable bit and the shutdown field pulses both requests in the same cycle. With a successful start, `cstsQ` becomes 32'h9.
- R8: In virtual-function mode with `vfOnline` low, configuration writes cause no request pulse and leave `ccQ` unchanged.
- R9: A `funcRst` cycle clears `ccQ` and `intMaskQ`. It sets `cstsQ` to 32'h2 if virtual-function mode is active and the function is offline, and to zero otherwise. It overrides any write in the same cycle and suppresses that write's requests.
- R10: A write to 0x0C ORs its data into the interrupt mask. A write to 0x10 clears the mask bits that are set in its data. Writes to any other offset change nothing.
- R11: While `rst_n` is low, all registers read zero and both requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Byte offset of the write |
| wrData | input | 32 | Write data |
| vfMode | input | 1 | Selects virtual-function behaviour |
| vfOnline | input | 1 | Virtual function is online |
| funcRst | input | 1 | Function-level reset request |
| startOk | input | 1 | Result of the start request, valid in the same cycle |
| startReq | output | 1 | One-cycle controller start request |
| shutdownReq | output | 1 | One-cycle shutdown request |
| ccQ | output | 32 | Configuration register |
| cstsQ | output | 32 | Status register |
| intMaskQ | output | 32 | Interrupt mask |

## Verification
The configuration register is driven through each single-field transition:

- enable rising with a successful start and with a failed start
- shutdown rising and shutdown falling while enabled
- enable falling alone
- enable falling together with a shutdown rise

These cases separate the shutdown-first ordering from the reset-path override. A combined enable-and-shutdown write shows that both edges are detected against the old value in one cycle. Virtual-function runs switch between online and offline. They show that writes are discarded when offline and that the function reset picks its status by online state, including a reset that collides with a write. Writes to the mask offsets and to an unmapped offset confirm the set and clear semantics and that unmapped writes are ignored.

// File: rtl/ccfg_pkg.sv
package ccfg_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned CC_EN_BIT  = 0;
  localparam int unsigned CC_SHN_LO  = 14;
  localparam int unsigned SHN_W      = 2;
  localparam int unsigned CC_SHN_HI  = CC_SHN_LO + SHN_W - 1;
  localparam int unsigned ST_RDY_BIT = 0;
  localparam int unsigned ST_CFS_BIT = 1;
  localparam int unsigned ST_SHS_LO  = 2;
  localparam int unsigned SHS_W      = 2;
  localparam int unsigned ST_SHS_HI  = ST_SHS_LO + SHS_W - 1;
  localparam logic [SHS_W-1:0] SHS_DONE = 2'b10;
  localparam logic [REG_W-1:0] FATAL_ONLY = REG_W'(1) << ST_CFS_BIT;

  typedef struct packed {
    logic ccLoad;
    logic maskSet;
    logic maskClr;
    logic doReset;
    logic shsSet;
    logic shsClr;
    logic rdySet;
    logic fatalOnly;
  } strobe_t;
endpackage

// File: rtl/ccfg_ctrl.sv
module ccfg_ctrl
  import ccfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_INTMS = 'h0C,
  parameter logic [ADDR_W-1:0] OFF_INTMC = 'h10,
  parameter logic [ADDR_W-1:0] OFF_CC    = 'h14
) (
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [REG_W-1:0]  ccQ,
  input  logic              vfMode,
  input  logic              vfOnline,
  input  logic              funcRst,
  input  logic              startOk,
  output strobe_t           stb,
  output logic              startReq,
  output logic              shutdownReq
);
  logic ccAccept;
  logic vfOffline;
  logic [SHN_W-1:0] oldShn, newShn;
  logic shnRise, shnFall, enRise, enFall;

  always_comb begin
    vfOffline = vfMode && !vfOnline;
    ccAccept  = wrValid && (wrAddr == OFF_CC) && !vfOffline && !funcRst;
    oldShn    = ccQ[CC_SHN_HI:CC_SHN_LO];
    newShn    = wrData[CC_SHN_HI:CC_SHN_LO];
    shnRise   = ccAccept && (newShn != '0) && (oldShn == '0);
    shnFall   = ccAccept && (newShn == '0) && (oldShn != '0);
    enRise    = ccAccept && wrData[CC_EN_BIT] && !ccQ[CC_EN_BIT];
    enFall    = ccAccept && !wrData[CC_EN_BIT] && ccQ[CC_EN_BIT];

    stb           = '0;
    stb.doReset   = funcRst || enFall;
    stb.ccLoad    = ccAccept && !enFall;
    stb.maskSet   = wrValid && (wrAddr == OFF_INTMS) && !funcRst;
    stb.maskClr   = wrValid && (wrAddr == OFF_INTMC) && !funcRst;
    stb.shsSet    = shnRise;
    stb.shsClr    = shnFall;
    stb.rdySet    = enRise && startOk;
    stb.fatalOnly = enRise && !startOk;

    startReq    = enRise;
    shutdownReq = shnRise;
  end
endmodule

// File: rtl/ccfg_regs.sv
module ccfg_regs
  import ccfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          stb,
  input  logic [REG_W-1:0] wrData,
  input  logic             vfMode,
  input  logic             vfOnline,
  output logic [REG_W-1:0] ccQ,
  output logic [REG_W-1:0] cstsQ,
  output logic [REG_W-1:0] intMaskQ
);
  logic [REG_W-1:0] cstsNext;
  logic [REG_W-1:0] maskNext;
  logic [REG_W-1:0] resetStatus;

  always_comb begin
    resetStatus = (vfMode && !vfOnline) ? FATAL_ONLY : '0;

    cstsNext = cstsQ;
    if (stb.shsSet)
      cstsNext[ST_SHS_HI:ST_SHS_LO] = SHS_DONE;
    else if (stb.shsClr)
      cstsNext[ST_SHS_HI:ST_SHS_LO] = '0;
    if (stb.rdySet)
      cstsNext[ST_RDY_BIT] = 1'b1;
    if (stb.fatalOnly)
      cstsNext = FATAL_ONLY;

    maskNext = intMaskQ;
    if (stb.maskSet) maskNext = maskNext | wrData;
    if (stb.maskClr) maskNext = maskNext & ~wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccQ      <= '0;
      cstsQ    <= '0;
      intMaskQ <= '0;
    end else if (stb.doReset) begin
      ccQ      <= '0;
      cstsQ    <= resetStatus;
      intMaskQ <= '0;
    end else begin
      if (stb.ccLoad) ccQ <= wrData;
      cstsQ    <= cstsNext;
      intMaskQ <= maskNext;
    end
  end
endmodule

// File: rtl/ctrl_cfg_regs.sv
module ctrl_cfg_regs
  import ccfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_INTMS = 'h0C,
  parameter logic [ADDR_W-1:0] OFF_INTMC = 'h10,
  parameter logic [ADDR_W-1:0] OFF_CC    = 'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              vfMode,
  input  logic              vfOnline,
  input  logic              funcRst,
  input  logic              startOk,
  output logic              startReq,
  output logic              shutdownReq,
  output logic [31:0]       ccQ,
  output logic [31:0]       cstsQ,
  output logic [31:0]       intMaskQ
);
  strobe_t stb;

  ccfg_ctrl #(
    .ADDR_W(ADDR_W), .OFF_INTMS(OFF_INTMS), .OFF_INTMC(OFF_INTMC), .OFF_CC(OFF_CC)
  ) uCtrl (
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .ccQ(ccQ),
    .vfMode(vfMode), .vfOnline(vfOnline), .funcRst(funcRst), .startOk(startOk),
    .stb(stb), .startReq(startReq), .shutdownReq(shutdownReq)
  );

  ccfg_regs uRegs (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wrData(wrData),
    .vfMode(vfMode), .vfOnline(vfOnline),
    .ccQ(ccQ), .cstsQ(cstsQ), .intMaskQ(intMaskQ)
  );
endmodule

// File: rtl/ccfg_chk.sv
module ccfg_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_CC = 'h14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [31:0]       wrData,
  input logic              vfMode,
  input logic              vfOnline,
  input logic              funcRst,
  input logic              startOk,
  input logic              startReq,
  input logic              shutdownReq,
  input logic [31:0]       ccQ,
  input logic [31:0]       cstsQ,
  input logic [31:0]       intMaskQ
);
  p_start_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    startReq && !startOk |=> cstsQ == 32'h2);

  p_start_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    startReq && startOk |=> cstsQ[0]);

  p_shut_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shutdownReq && wrData[0] && !(startReq && !startOk) |=> cstsQ[3:2] == 2'b10);

  p_offline_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrValid && wrAddr == OFF_CC && vfMode && !vfOnline |-> !startReq && !shutdownReq);

  p_offline_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrValid && wrAddr == OFF_CC && vfMode && !vfOnline && !funcRst |=> $stable(ccQ));

  p_vf_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    funcRst && vfMode && !vfOnline |=> cstsQ == 32'h2 && ccQ == 32'h0 && intMaskQ == 32'h0);

  p_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrValid && wrAddr == OFF_CC && ccQ[0] && !wrData[0] && !funcRst && !(vfMode && !vfOnline)
    |=> ccQ == 32'h0 && intMaskQ == 32'h0 && cstsQ == 32'h0);
endmodule

bind ctrl_cfg_regs ccfg_chk #(.ADDR_W(ADDR_W), .OFF_CC(OFF_CC)) uChk (
  .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
  .vfMode(vfMode), .vfOnline(vfOnline), .funcRst(funcRst), .startOk(startOk),
  .startReq(startReq), .shutdownReq(shutdownReq),
  .ccQ(ccQ), .cstsQ(cstsQ), .intMaskQ(intMaskQ)
);

// File: tb/sim_ctrl_cfg_regs.sv
module sim_ctrl_cfg_regs;
  localparam int CLK_P = 10;
  localparam logic [7:0] A_SET = 8'h0C;
  localparam logic [7:0] A_CLR = 8'h10;
  localparam logic [7:0] A_CC  = 8'h14;
  localparam logic [7:0] A_NONE = 8'h40;

  logic clk = 0, rst_n = 0;
  logic wrValid = 0, vfMode = 0, vfOnline = 0, funcRst = 0, startOk = 0;
  logic [7:0] wrAddr = 0;
  logic [31:0] wrData = 0;
  logic startReq, shutdownReq;
  logic [31:0] ccQ, cstsQ, intMaskQ;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] cc, csts, mask;
    logic st, sh, obsSt, obsSh;
    string tag;
  } item_t;
  item_t q[$];

  logic [31:0] mCc = 0, mCsts = 0, mMask = 0;

  ctrl_cfg_regs u0 (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .vfMode(vfMode), .vfOnline(vfOnline), .funcRst(funcRst), .startOk(startOk),
    .startReq(startReq), .shutdownReq(shutdownReq),
    .ccQ(ccQ), .cstsQ(cstsQ), .intMaskQ(intMaskQ)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic doWr(input logic [7:0] a, input logic [31:0] d, input logic ok,
                      input logic fr, input string tag);
    item_t it;
    logic acc, shR, shF, eR, eF;
    @(negedge clk);
    wrValid = (a != A_NONE); wrAddr = a; wrData = d; startOk = ok; funcRst = fr;
    it.st = 0; it.sh = 0;
    acc = (a == A_CC) && !(vfMode && !vfOnline) && !fr;
    if (fr) begin
      mCc = 0; mMask = 0; mCsts = (vfMode && !vfOnline) ? 32'h2 : 32'h0;
    end else begin
      if (a == A_SET) mMask = mMask | d;
      if (a == A_CLR) mMask = mMask & ~d;
      if (acc) begin
        shR = (d[15:14] != 0) && (mCc[15:14] == 0);
        shF = (d[15:14] == 0) && (mCc[15:14] != 0);
        eR  = d[0] && !mCc[0];
        eF  = !d[0] && mCc[0];
        it.sh = shR; it.st = eR;
        if (shR) mCsts[3:2] = 2'b10;
        else if (shF) mCsts[3:2] = 2'b00;
        if (eR) begin
          if (ok) mCsts[0] = 1'b1; else mCsts = 32'h2;
        end
        if (eF) begin mCc = 0; mMask = 0; mCsts = 0; end
        else mCc = d;
      end
    end
    it.cc = mCc; it.csts = mCsts; it.mask = mMask; it.tag = tag;
    #1;
    it.obsSt = startReq; it.obsSh = shutdownReq;
    q.push_back(it);
    @(negedge clk);
    wrValid = 0; funcRst = 0; startOk = 0; wrAddr = 0; wrData = 0;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        chk(it.tag, "startReq", {31'b0, it.obsSt}, {31'b0, it.st});
        chk(it.tag, "shutdownReq", {31'b0, it.obsSh}, {31'b0, it.sh});
        chk(it.tag, "ccQ", ccQ, it.cc);
        chk(it.tag, "cstsQ", cstsQ, it.csts);
        chk(it.tag, "intMaskQ", intMaskQ, it.mask);
      end
    end
  end

  initial begin : watchdog
    #(CLK_P * 100000);
    miscompares++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "ccQ", ccQ, 0);
    chk("R11", "cstsQ", cstsQ, 0);
    chk("R11", "intMaskQ", intMaskQ, 0);
    chk("R11", "reqs", {30'b0, startReq, shutdownReq}, 0);
    rst_n = 1;
    // R10 mask set/clear and unmapped offset
    doWr(A_SET, 32'h0000_000F, 0, 0, "R10");
    doWr(A_CLR, 32'h0000_0005, 0, 0, "R10");
    doWr(8'h20, 32'hFFFF_FFFF, 0, 0, "R10");
    // R1 store full value without enable
    doWr(A_CC, 32'h0046_0000, 0, 0, "R1");
    // R4 enable rise, start ok
    doWr(A_CC, 32'h0046_0001, 1, 0, "R4");
    // R2 shutdown rise while enabled
    doWr(A_CC, 32'h0046_4001, 0, 0, "R2");
    // R3 shutdown fall
    doWr(A_CC, 32'h0046_0001, 0, 0, "R3");
    // R6 enable fall
    doWr(A_CC, 32'h0046_0000, 0, 0, "R6");
    // R5 failed start
    doWr(A_CC, 32'h0000_0001, 0, 0, "R5");
    doWr(A_CC, 32'h0000_0000, 0, 0, "R6");
    // R7 enable and shutdown in one write
    doWr(A_CC, 32'h0000_4001, 1, 0, "R7");
    doWr(A_CC, 32'h0000_0000, 0, 0, "R6");
    doWr(A_CC, 32'h0000_0001, 1, 0, "R4");
    doWr(A_SET, 32'h0000_00F0, 0, 0, "R10");
    // R6 disable with shutdown rise: request fires, reset wins
    doWr(A_CC, 32'h0000_4000, 0, 0, "R6");
    // virtual function, offline
    vfMode = 1; vfOnline = 0;
    doWr(A_NONE, 32'h0, 0, 1, "R9");
    doWr(A_CC, 32'h0000_4001, 1, 0, "R8");
    // online
    vfOnline = 1;
    doWr(A_NONE, 32'h0, 0, 1, "R9");
    doWr(A_CC, 32'h0000_0001, 1, 0, "R4");
    doWr(A_SET, 32'h0000_0003, 0, 0, "R10");
    // reset colliding with a write
    doWr(A_CC, 32'h0000_4000, 0, 1, "R9");
    doWr(A_CC, 32'h0000_0001, 1, 0, "R4");
    vfOnline = 0;
    doWr(A_CC, 32'h0000_0000, 0, 0, "R8");
    doWr(A_NONE, 32'h0, 0, 1, "R9");
    repeat (4) @(negedge clk);
    summary();
  end
endmodule